// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Unit

This block gathers fourteen interrupt request lines from the FIFO endpoints and the transfer engine into one shared interrupt for a small 8-bit processor. Each request line has its own sticky pending bit. A per-source enable decides whether that pending bit can take part. A fixed-priority arbiter picks the winning enabled pending source and turns it into a vector byte.

The processor takes the interrupt and jumps to a fixed dispatch address, where a jump instruction is stored. When that dispatch address is fetched, the unit captures the current vector. The page byte of the jump target passes through from memory. When autovectoring is on, the unit puts the captured vector byte in place of the low byte on the code-fetch data path. The jump then lands on the handler entry for that source within the page. When autovectoring is off, every fetch passes through unchanged.

Top module: `irq_autovec`

## Requirements
- R1: A pending bit is set by a rising edge on its request line, and the set is visible one clock later. A request held high after its bit is cleared does not set the bit again.
- R2: A one-cycle clear strobe on a source clears its pending bit on the next clock. If a rising edge arrives in the same cycle as the clear, the bit stays set.
- R3: `irq_o` is high exactly when at least one pending source has its enable bit set. A pending source whose enable is low keeps its pending state and does not drive `irq_o`.
- R4: Among enabled pending sources, the lowest bit index wins. The bit order is fixed: bits 0 to 3 are the programmable-level flags of endpoints 2, 4, 6 and 8; bits 4 to 7 are the empty flags in the same endpoint order; bits 8 to 11 are the full flags in the same order; bit 12 is transfer-done; bit 13 is the waveform event.
- R5: The vector for winning bit index k is 0x80 + 4*k, which covers 0x80 to 0xB4. When no enabled source is pending, the vector is 0x80.
- R6: The vector is captured on a clock in which `fetch_vld_i` is high and `fetch_addr_i` is 0x0553. It holds its value until the next such capture. A request that arrives between the capture and the 0x0555 fetch does not change the byte that is delivered.
- R7: When `av_en_i` is 1 and `fetch_addr_i` is 0x0555, `fetch_data_o` carries the captured vector.
- R8: In every other case, `fetch_data_o` equals `mem_data_i`. This includes the page byte at 0x0554 and every fetch while `av_en_i` is 0.
- R9: After reset, all pending bits are clear, `irq_o` is 0 and the captured vector is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 14 | Interrupt request lines, bit order as in R4 |
| en_i | input | 14 | Per-source enable |
| clr_i | input | 14 | Per-source write-one-to-clear strobe |
| av_en_i | input | 1 | Autovector enable |
| fetch_vld_i | input | 1 | Code fetch in progress this cycle |
| fetch_addr_i | input | 16 | Code-fetch address |
| mem_data_i | input | 8 | Read data from code memory |
| irq_o | output | 1 | Shared interrupt request |
| fetch_data_o | output | 8 | Fetch data after vector substitution |

## Verification
The bound checker watches several rules on every cycle:
- a rising request always leaves its bit pending, and a clear without a request always empties it;
- `irq_o` stays low whenever no enable is set;
- the captured vector only moves at a dispatch fetch;
- the fetch data either equals memory or is a legal vector.

Only the bench's scenarios can show that the arbiter picks the right winner among many pending sources. The same applies to masked sources keeping their state, to a late higher-priority request not splitting the jump target, and to a level held high not setting its bit again. The bench checks all of these against its behavioural model, with autovectoring both on and off.

// File: rtl/irq_av_pkg.sv
package irq_av_pkg;
  localparam int unsigned SRC_COUNT = 14;

  typedef enum logic [3:0] {
    SRC_LVL_EP2, SRC_LVL_EP4, SRC_LVL_EP6, SRC_LVL_EP8,
    SRC_EMP_EP2, SRC_EMP_EP4, SRC_EMP_EP6, SRC_EMP_EP8,
    SRC_FUL_EP2, SRC_FUL_EP4, SRC_FUL_EP6, SRC_FUL_EP8,
    SRC_XFER_DONE, SRC_WAVE_EVT
  } src_id_e;

  // vector byte for a winning source index
  function automatic int av_vec(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic req_q;
    logic pend_q;
    logic pend_d;
    logic rise;
    logic pend_upd;

    always_comb begin
      rise     = req_i[g] & ~req_q;
      pend_upd = rise | clr_i[g];
      pend_d   = rise ? 1'b1 : 1'b0;   // a new edge beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q <= 1'b0;
      end else begin
        req_q <= req_i[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (pend_upd) begin
        pend_q <= pend_d;
      end
    end

    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 14,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from lowest priority upward so the lowest index ends up winning
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vecsel.sv
module irq_vecsel
  import irq_av_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int JMP_ADDR = 'h553,
  parameter int LOW_ADDR = 'h555,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              av_en_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] JMP_A  = ADDR_W'(JMP_ADDR);
  localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_ADDR);
  localparam logic [DATA_W-1:0] VEC_DF = DATA_W'(VEC_BASE);

  logic [DATA_W-1:0] vec_cur;
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] vec_d;
  logic              cap_en;

  always_comb begin
    vec_cur = hit_i ? DATA_W'(av_vec(VEC_BASE, VEC_STEP, int'(idx_i))) : VEC_DF;
    cap_en  = fetch_vld_i && (fetch_addr_i == JMP_A);
    vec_d   = vec_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= VEC_DF;
    end else if (cap_en) begin
      vec_q <= vec_d;
    end
  end

  always_comb begin
    if (av_en_i && (fetch_addr_i == LOW_A)) fetch_data_o = vec_q;
    else                                    fetch_data_o = mem_data_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/irq_autovec.sv
module irq_autovec
  import irq_av_pkg::*;
#(
  parameter int NSRC     = SRC_COUNT,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int JMP_ADDR = 'h553,
  parameter int LOW_ADDR = 'h555,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              av_en_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] fetch_data_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   act;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] vec_q;

  irq_pend #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (clr_i),
    .pend_o (pend)
  );

  assign act   = pend & en_i;
  assign irq_o = |act;

  irq_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
    .act_i (act),
    .hit_o (hit),
    .idx_o (idx)
  );

  irq_vecsel #(
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .JMP_ADDR (JMP_ADDR),
    .LOW_ADDR (LOW_ADDR),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_vecsel (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit),
    .idx_i        (idx),
    .av_en_i      (av_en_i),
    .fetch_vld_i  (fetch_vld_i),
    .fetch_addr_i (fetch_addr_i),
    .mem_data_i   (mem_data_i),
    .fetch_data_o (fetch_data_o),
    .vec_o        (vec_q)
  );
endmodule

// File: rtl/irq_autovec_chk.sv
module irq_autovec_chk #(
  parameter int NSRC     = 14,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int JMP_ADDR = 'h553,
  parameter int LOW_ADDR = 'h555,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   req_i,
  input logic [NSRC-1:0]   en_i,
  input logic [NSRC-1:0]   clr_i,
  input logic              av_en_i,
  input logic              fetch_vld_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [DATA_W-1:0] mem_data_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] fetch_data_o,
  input logic [NSRC-1:0]   pend,
  input logic [DATA_W-1:0] vec_q
);
  localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NSRC - 1);

  logic [NSRC-1:0] req_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_seen <= '0;
    else        req_seen <= req_i;
  end

  // R1: a rising request is pending on the next clock
  p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(req_i & ~req_seen)) == $past(req_i & ~req_seen)));

  // R2: a clear with no request leaves the bit empty
  p_clr_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr_i & ~req_i)) == '0));

  // R3: no enable means no interrupt
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);

  // R6: captured vector moves only at a dispatch fetch
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_vld_i && fetch_addr_i == ADDR_W'(JMP_ADDR)) |=> (vec_q == $past(vec_q)));

  // R7: substituted byte lies within the vector range
  p_sub_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (av_en_i && fetch_addr_i == ADDR_W'(LOW_ADDR)) |->
      (int'(fetch_data_o) >= VEC_BASE && int'(fetch_data_o) <= VEC_TOP));

  // R8: pass-through everywhere else
  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!av_en_i || fetch_addr_i != ADDR_W'(LOW_ADDR)) |-> (fetch_data_o == mem_data_i));
endmodule

bind irq_autovec irq_autovec_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .JMP_ADDR(JMP_ADDR),
  .LOW_ADDR(LOW_ADDR), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i), .clr_i(clr_i),
  .av_en_i(av_en_i), .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i),
  .mem_data_i(mem_data_i), .irq_o(irq_o), .fetch_data_o(fetch_data_o),
  .pend(pend), .vec_q(vec_q)
);

// File: tb/irq_autovec_tb.sv
`timescale 1ns/1ps
module irq_autovec_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] req, en, clr;
  logic        av, vld;
  logic [15:0] addr;
  logic [7:0]  mem;
  logic        irq;
  logic [7:0]  fdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_autovec u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .clr_i(clr),
    .av_en_i(av), .fetch_vld_i(vld), .fetch_addr_i(addr), .mem_data_i(mem),
    .irq_o(irq), .fetch_data_o(fdata)
  );

  // behavioural reference
  bit m_pend[14];
  bit m_prev[14];
  int m_vec;

  function automatic int m_win();
    for (int i = 0; i < 14; i++)
      if (m_pend[i] && en[i]) return 'h80 + 4 * i;
    return 'h80;
  endfunction

  function automatic bit m_irq();
    for (int i = 0; i < 14; i++)
      if (m_pend[i] && en[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 14; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
      m_vec = 'h80;
    end else begin
      int w;
      w = m_win();
      for (int i = 0; i < 14; i++) begin
        if (req[i] && !m_prev[i]) m_pend[i] = 1;
        else if (clr[i])          m_pend[i] = 0;
        m_prev[i] = req[i];
      end
      if (vld && addr == 16'h0553) m_vec = w;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk("R3 irq", int'(irq), int'(m_irq()));
      if (av && addr == 16'h0555) chk("R7 fetch", int'(fdata), m_vec);
      else                        chk("R8 fetch", int'(fdata), int'(mem));
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic dispatch(input int exp55, input string tag);
    cyc(); vld = 1; addr = 16'h0553; mem = 8'h02;
    cyc(); addr = 16'h0554; mem = 8'h12;
    #2 chk("R8 page byte", int'(fdata), 'h12);
    cyc(); addr = 16'h0555; mem = 8'h34;
    #2 chk(tag, int'(fdata), exp55);
    cyc(); vld = 0; addr = 16'h0000;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R9 act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = '0; en = '0; clr = '0; av = 1; vld = 0;
    addr = 16'h0555; mem = 8'h11;
    repeat (3) cyc();
    #2 chk("R9 reset irq", int'(irq), 0);
    chk("R9 reset vector", int'(fdata), 'h80);
    rst_n = 1;
    cyc(); en = '1; addr = 16'h0000;

    // R1: single rising edge on bit 5
    cyc(); req[5] = 1;
    cyc(); #2 chk("R1 irq after edge", int'(irq), 1);
    dispatch('h94, "R5 vector bit5");

    // R4: bits 2 and 9 added, bit 2 wins
    cyc(); req[2] = 1; req[9] = 1;
    dispatch('h88, "R4 lowest index wins");

    // R6: higher priority arrives after capture
    cyc(); vld = 1; addr = 16'h0553;
    cyc(); addr = 16'h0554; req[0] = 1;
    cyc(); addr = 16'h0555;
    #2 chk("R6 no split", int'(fdata), 'h88);
    cyc(); vld = 0; addr = 0;
    dispatch('h80, "R4 bit0 wins");

    // R2 + R1: clear 0 and 2 with requests still high
    cyc(); clr[0] = 1; clr[2] = 1;
    cyc(); clr = '0;
    cyc();
    dispatch('h94, "R2 cleared, held level no reset");

    // R3: mask all pending
    cyc(); en = 14'h2000;
    cyc(); #2 chk("R3 masked irq", int'(irq), 0);
    dispatch('h80, "R5 default vector");
    cyc(); en = '1;
    cyc(); #2 chk("R3 unmasked irq", int'(irq), 1);

    // R2: clear and edge in same cycle, bit 13
    cyc(); clr = '1; req[13] = 1;
    cyc(); clr = '0; en = 14'h2000;
    cyc(); #2 chk("R2 edge beats clear", int'(irq), 1);
    dispatch('hB4, "R5 vector bit13");

    // R8: autovector off
    cyc(); av = 0;
    dispatch('h34, "R8 av off passthrough");

    // random phase
    cyc(); req = '0; clr = '1; en = '1;
    cyc(); clr = '0;
    for (int k = 0; k < 600; k++) begin
      cyc();
      req = 14'($urandom);
      en  = 14'($urandom);
      clr = ($urandom % 4 == 0) ? 14'($urandom) : 14'h0;
      av  = 1'($urandom);
      vld = 1'($urandom);
      case ($urandom % 4)
        0: addr = 16'h0553;
        1: addr = 16'h0554;
        2: addr = 16'h0555;
        default: addr = 16'($urandom);
      endcase
      mem = 8'($urandom);
    end
    cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule